// File: doc/BRIEF.md
# Byte-Lane Load/Store Aligner

This block sits between a register-side load/store port and a memory that is one word wide. It takes a byte address and a byte count. The low address bits pick the starting byte lane inside the word, and the upper bits are sent to memory as the word address. From the byte count and the lane the block builds a byte mask that is twice the word width. The low half of that mask drives the memory byte write enables. The high half reports when an access runs past the end of the word.

For a store, the register data is shifted up so that its low bytes land in the addressed lanes. The write enables and the shifted data appear in the same cycle as the store strobe. For a load, the memory word is first masked to the addressed bytes and then shifted down, so the requested bytes sit at the bottom. This result is captured on the load strobe and presented one cycle later with a one-cycle valid pulse. The block does not split an access that crosses the word boundary; it only flags it.

Top module: `byte_lane_aligner`

## Requirements
- R1: After reset, ld_ok_o is low and ld_data_o is all zeros until the first load strobe.
- R2: word_addr_o always equals byte_addr_i shifted right by 3, so the low 3 address bits are dropped.
- R3: While st_valid_i is high, bit b of byte_en_o is set exactly when lane <= b < lane + xfer_len_i, where lane is byte_addr_i[2:0]. While st_valid_i is low, byte_en_o is all zeros.
- R4: A byte count of 0 gives no byte enables, a load result of zero, and misalign_o low, for every lane.
- R5: misalign_o is high exactly when lane + xfer_len_i is greater than 8, meaning some bit of the upper half of the 16-bit mask is set.
- R6: mem_wdata_o equals st_data_i shifted left by 8 × lane bits, truncated to 64 bits.
- R7: In the cycle after a clock edge with ld_valid_i high, ld_ok_o is high. ld_data_o then holds the memory bytes from lane up to lane + xfer_len_i - 1, stopping at byte 7, moved down to byte 0 onward, with all other bytes zero.
- R8: After a clock edge with ld_valid_i low, ld_ok_o is low and ld_data_o keeps its previous value, whatever mem_rdata_i does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid_i | input | 1 | Load strobe: capture the aligned read data |
| st_valid_i | input | 1 | Store strobe: enable byte writes this cycle |
| xfer_len_i | input | 4 | Transfer length in bytes (0..15) |
| byte_addr_i | input | 16 | Byte address |
| st_data_i | input | 64 | Store data, right-justified |
| mem_rdata_i | input | 64 | Word read from memory |
| word_addr_o | output | 13 | Word address sent to memory |
| byte_en_o | output | 8 | Per-byte write enables |
| mem_wdata_o | output | 64 | Store data shifted into the addressed lanes |
| ld_data_o | output | 64 | Aligned, masked load data (registered) |
| ld_ok_o | output | 1 | One-cycle pulse marking ld_data_o valid |
| misalign_o | output | 1 | The access crosses the word boundary |

## Verification
On every cycle the assertions check four things. Write enables stay off without a store strobe. The number of enabled lanes never exceeds the byte count. A crossing access always enables the top lane. The load register pulses valid after a strobe and otherwise holds its value. Only the bench scenarios can show the exact lane pattern, the shifted store word and the masked load bytes. For that, the bench sweeps every byte count against every lane at two word addresses and computes each expected word byte by byte.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  localparam int unsigned BYTE_W = 8;

  function automatic int unsigned lane_bits(input int unsigned lanes);
    return $clog2(lanes);
  endfunction
endpackage

// File: rtl/lsa_mask_gen.sv
module lsa_mask_gen #(
  parameter int unsigned LANES = 8,
  parameter int unsigned LEN_W = 4,
  localparam int unsigned LB_W   = lsa_pkg::lane_bits(LANES),
  localparam int unsigned MASK_W = 2 * LANES,
  localparam int unsigned SUM_W  = (LB_W > LEN_W ? LB_W : LEN_W) + 1
) (
  input  logic [LB_W-1:0]   lane_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [MASK_W-1:0] mask_o
);
  logic [SUM_W-1:0] lo, hi;

  always_comb begin
    lo = SUM_W'(lane_i);
    hi = SUM_W'(lane_i) + SUM_W'(len_i);
  end

  // unary run of ones from lane to lane+len-1 across a double-width window
  for (genvar i = 0; i < MASK_W; i++) begin : g_bit
    assign mask_o[i] = (SUM_W'(i) >= lo) && (SUM_W'(i) < hi);
  end
endmodule

// File: rtl/lsa_store_path.sv
module lsa_store_path #(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned LANES = DATA_W / lsa_pkg::BYTE_W,
  localparam int unsigned LB_W  = lsa_pkg::lane_bits(LANES),
  localparam int unsigned SH_W  = LB_W + 3
) (
  input  logic              st_valid_i,
  input  logic [LB_W-1:0]   lane_i,
  input  logic [LANES-1:0]  lane_mask_i,
  input  logic [DATA_W-1:0] st_data_i,
  output logic [DATA_W-1:0] wdata_o,
  output logic [LANES-1:0]  byte_en_o
);
  logic [SH_W-1:0] shamt;

  always_comb begin
    shamt     = {lane_i, 3'b000};
    wdata_o   = st_data_i << shamt;
    byte_en_o = st_valid_i ? lane_mask_i : '0;
  end
endmodule

// File: rtl/lsa_load_path.sv
module lsa_load_path #(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned LANES = DATA_W / lsa_pkg::BYTE_W,
  localparam int unsigned LB_W  = lsa_pkg::lane_bits(LANES),
  localparam int unsigned SH_W  = LB_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid_i,
  input  logic [LB_W-1:0]   lane_i,
  input  logic [LANES-1:0]  lane_mask_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] ld_data_o,
  output logic              ld_ok_o
);
  logic [DATA_W-1:0] bit_mask, aligned;
  logic [DATA_W-1:0] data_d, data_q;
  logic              ok_d, ok_q;
  logic [SH_W-1:0]   shamt;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign bit_mask[b*lsa_pkg::BYTE_W +: lsa_pkg::BYTE_W] = {lsa_pkg::BYTE_W{lane_mask_i[b]}};
  end

  always_comb begin
    shamt   = {lane_i, 3'b000};
    aligned = (rdata_i & bit_mask) >> shamt;
    data_d  = ld_valid_i ? aligned : data_q;
    ok_d    = ld_valid_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ok_q   <= 1'b0;
    end else begin
      data_q <= data_d;
      ok_q   <= ok_d;
    end
  end

  assign ld_data_o = data_q;
  assign ld_ok_o   = ok_q;

  // R7
  ld_ok_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid_i |=> ld_ok_o);

  // R8
  ld_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid_i |=> (!ld_ok_o && $stable(ld_data_o)));
endmodule

// File: rtl/byte_lane_aligner.sv
module byte_lane_aligner #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LEN_W  = 4,
  localparam int unsigned LANES = DATA_W / lsa_pkg::BYTE_W,
  localparam int unsigned LB_W  = lsa_pkg::lane_bits(LANES),
  localparam int unsigned WA_W  = ADDR_W - LB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid_i,
  input  logic              st_valid_i,
  input  logic [LEN_W-1:0]  xfer_len_i,
  input  logic [ADDR_W-1:0] byte_addr_i,
  input  logic [DATA_W-1:0] st_data_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [WA_W-1:0]   word_addr_o,
  output logic [LANES-1:0]  byte_en_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [DATA_W-1:0] ld_data_o,
  output logic              ld_ok_o,
  output logic              misalign_o
);
  logic [LB_W-1:0]    lane;
  logic [2*LANES-1:0] mask;

  assign lane        = byte_addr_i[LB_W-1:0];
  assign word_addr_o = byte_addr_i[ADDR_W-1:LB_W];

  lsa_mask_gen #(.LANES(LANES), .LEN_W(LEN_W)) u_mask (
    .lane_i (lane),
    .len_i  (xfer_len_i),
    .mask_o (mask)
  );

  // spill into the upper half means the run passed the last lane
  assign misalign_o = |mask[2*LANES-1:LANES];

  lsa_store_path #(.DATA_W(DATA_W)) u_store (
    .st_valid_i  (st_valid_i),
    .lane_i      (lane),
    .lane_mask_i (mask[LANES-1:0]),
    .st_data_i   (st_data_i),
    .wdata_o     (mem_wdata_o),
    .byte_en_o   (byte_en_o)
  );

  lsa_load_path #(.DATA_W(DATA_W)) u_load (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld_valid_i  (ld_valid_i),
    .lane_i      (lane),
    .lane_mask_i (mask[LANES-1:0]),
    .rdata_i     (mem_rdata_i),
    .ld_data_o   (ld_data_o),
    .ld_ok_o     (ld_ok_o)
  );

  // R3
  en_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !st_valid_i |-> (byte_en_o == '0));

  // R3
  en_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid_i |-> ($countones(byte_en_o) <= int'(xfer_len_i)));

  // R4
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_len_i == '0) |-> (!misalign_o && byte_en_o == '0));

  // R5
  cross_top_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (misalign_o && st_valid_i) |-> byte_en_o[LANES-1]);
endmodule

// File: tb/byte_lane_aligner_bench.sv
module byte_lane_aligner_bench;
  logic        clk = 1'b0;
  logic        rst_n, ld_valid, st_valid;
  logic [3:0]  xfer_len;
  logic [15:0] byte_addr;
  logic [63:0] st_data, rdata;
  logic [12:0] word_addr;
  logic [7:0]  byte_en;
  logic [63:0] wdata, ld_data;
  logic        ld_ok, misalign;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  byte_lane_aligner u_byte_lane_aligner (
    .clk(clk), .rst_n(rst_n), .ld_valid_i(ld_valid), .st_valid_i(st_valid),
    .xfer_len_i(xfer_len), .byte_addr_i(byte_addr), .st_data_i(st_data),
    .mem_rdata_i(rdata), .word_addr_o(word_addr), .byte_en_o(byte_en),
    .mem_wdata_o(wdata), .ld_data_o(ld_data), .ld_ok_o(ld_ok),
    .misalign_o(misalign)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] bases [2];
    bases[0] = 16'h0000;
    bases[1] = 16'hA5C0;
    rst_n = 1'b0; ld_valid = 1'b0; st_valid = 1'b0;
    xfer_len = '0; byte_addr = '0; st_data = '0; rdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk(ld_ok == 1'b0, "R1 ld_ok", 64'(ld_ok), 64'd0);
    chk(ld_data == 64'd0, "R1 ld_data", ld_data, 64'd0);

    for (int bi = 0; bi < 2; bi++) begin
      for (int len = 0; len < 16; len++) begin
        for (int lane = 0; lane < 8; lane++) begin
          logic [7:0]  exp_en;
          logic [63:0] exp_ld, exp_wd;
          logic        exp_mis;
          @(negedge clk);
          byte_addr = bases[bi] | 16'(lane);
          xfer_len  = 4'(len);
          st_data   = 64'h8877665544332211 + 64'(len * 8 + lane) * 64'h0101010101010101;
          rdata     = 64'hF0E1D2C3B4A59687 ^ (64'(len * 8 + lane + bi) * 64'h0001000300050007);
          st_valid  = 1'b1;
          ld_valid  = 1'b1;
          exp_en = '0;
          exp_ld = '0;
          for (int b = 0; b < 8; b++) begin
            exp_en[b] = (b >= lane) && (b < lane + len);
            if ((b + lane < 8) && (b < len)) exp_ld[b*8 +: 8] = rdata[(b+lane)*8 +: 8];
          end
          exp_wd  = st_data << (8 * lane);
          exp_mis = (lane + len) > 8;
          #1;
          chk(word_addr == 13'(bases[bi] >> 3), "R2 word_addr", 64'(word_addr), 64'(bases[bi] >> 3));
          if (len == 0)
            chk(byte_en == 8'd0 && !misalign, "R4 zero length", 64'({misalign, byte_en}), 64'd0);
          else
            chk(byte_en == exp_en, "R3 byte_en", 64'(byte_en), 64'(exp_en));
          chk(misalign == exp_mis, "R5 misalign", 64'(misalign), 64'(exp_mis));
          chk(wdata == exp_wd, "R6 wdata", wdata, exp_wd);
          @(posedge clk);
          #1;
          chk(ld_ok == 1'b1, "R7 ld_ok", 64'(ld_ok), 64'd1);
          chk(ld_data == exp_ld, len == 0 ? "R4 load zero" : "R7 ld_data", ld_data, exp_ld);
          @(negedge clk);
          st_valid = 1'b0;
          ld_valid = 1'b0;
          rdata    = ~rdata;
          #1;
          chk(byte_en == 8'd0, "R3 idle enables", 64'(byte_en), 64'd0);
          @(posedge clk);
          #1;
          chk(ld_ok == 1'b0, "R8 ld_ok low", 64'(ld_ok), 64'd0);
          chk(ld_data == exp_ld, "R8 hold", ld_data, exp_ld);
        end
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule